// File: doc/BRIEF.md
# Block-Floating to Fixed-Point Expander

This block sits between a gain-stepped sample path and the decimation filters. Each incoming beat carries a 14-bit signed mantissa and a small exponent. The exponent counts how many 6 dB attenuation steps an earlier variable-gain stage applied to that sample. The block sign-extends the mantissa into a wider word and shifts it left by the exponent. This cancels the attenuation, so the filters see one linear scale. Gain steps made by the automatic gain loop in the middle of a burst then leave no settling transient behind the filters.

One exponent step equals one binary shift, and at most seven steps are honoured. The linear result therefore needs 21 significant bits. It is delivered in an output word of at least that width, 24 bits by default. The mantissa and its exponent arrive in the same beat and are captured together, so a gain change applies to exactly the sample it belongs to.

Both the input and the output are valid/ready streams, and the block holds one result register. A beat is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. It appears on the output one cycle later. The output stays stable while `out_valid` is high and `out_ready` is low. `in_ready` is high whenever the register is empty or is being drained in the same cycle, so a downstream stall propagates upstream in the same cycle and full throughput needs no extra buffer.

Top module: `bfx_expander`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `out_valid` is low.
- R2: For an exponent e in 0..7, the output equals the mantissa, read as two's complement, multiplied by 2^e, in the full output width.
- R3: An exponent above 7 is treated as 7. For example, mantissa -1 with exponent 15 gives -128.
- R4: Negative mantissas stay negative: every output bit from bit 20 up to the MSB equals the sign of the result, and the most negative mantissa (14'h2000) with exponent 7 gives 24'hF00000.
- R5: A beat accepted on one edge is presented with `out_valid` high after that edge. Back-to-back beats with `out_ready` high pass at one per cycle.
- R6: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold, and `in_ready` is low.
- R7: Every accepted beat leaves the output exactly once, with no beat lost or repeated across a stall.
- R8: The exponent used for a result is the one presented in the same beat as its mantissa. A change of exponent between adjacent beats affects only the later beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take the input beat this cycle |
| in_mant | input | 14 | Signed mantissa sample |
| in_exp | input | 4 | Count of 6 dB attenuation steps to undo |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | 24 | Signed linear fixed-point sample |

## Verification
On every cycle, the assertions check four things: the scaled value of each accepted beat against its own mantissa and exponent (clamping included), sign replication in the top output bits, the appearance of a result one cycle after acceptance, and output stability during a stall. Only the bench scenarios can show certain other behaviours. These include the exact numeric corner values, such as the most negative mantissa at full shift or the clamping of exponents 8 and 15. They also include the pairing of an exponent with its own sample when adjacent beats change exponent, and the absence of a lost or repeated beat across a stall and its release. Reset during active traffic is also covered only by the bench.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int MANT_W_DEF    = 14;
  localparam int EXP_W_DEF     = 4;
  localparam int MAX_SHIFT_DEF = 7;
  localparam int OUT_W_DEF     = 24;

  // Width of the linear value carried by the output word.
  function automatic int lin_width(input int mant_w, input int max_shift);
    return mant_w + max_shift;
  endfunction
endpackage

// File: rtl/bfx_exp_clamp.sv
module bfx_exp_clamp #(
  parameter int EXP_W     = 4,
  parameter int MAX_SHIFT = 7,
  parameter int SH_W      = 3
) (
  input  logic [EXP_W-1:0] exp_in,
  output logic [SH_W-1:0]  shamt
);
  localparam int EXP_CAP = (1 << EXP_W) - 1;

  generate
    if (EXP_CAP <= MAX_SHIFT) begin : g_no_clamp
      // Exponent field cannot exceed the limit.
      assign shamt = SH_W'(exp_in);
    end else begin : g_clamp
      assign shamt = (exp_in > EXP_W'(MAX_SHIFT)) ? SH_W'(MAX_SHIFT) : SH_W'(exp_in);
    end
  endgenerate
endmodule

// File: rtl/bfx_shift.sv
module bfx_shift #(
  parameter int MANT_W = 14,
  parameter int SH_W   = 3,
  parameter int OUT_W  = 24
) (
  input  logic [MANT_W-1:0] mant,
  input  logic [SH_W-1:0]   shamt,
  output logic [OUT_W-1:0]  lin
);
  logic [OUT_W-1:0] widened;

  // Replicate the sign so the shift keeps negative samples negative.
  assign widened = {{(OUT_W-MANT_W){mant[MANT_W-1]}}, mant};
  assign lin     = widened << shamt;
endmodule

// File: rtl/bfx_out_stage.sv
module bfx_out_stage #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  // Register is free when empty or drained on this edge.
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) out_data <= in_data;
  end
endmodule

// File: rtl/bfx_expander.sv
module bfx_expander #(
  parameter int MANT_W    = bfx_pkg::MANT_W_DEF,
  parameter int EXP_W     = bfx_pkg::EXP_W_DEF,
  parameter int MAX_SHIFT = bfx_pkg::MAX_SHIFT_DEF,
  parameter int OUT_W     = bfx_pkg::OUT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MANT_W-1:0] in_mant,
  input  logic [EXP_W-1:0]  in_exp,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_data
);
  localparam int LIN_W = bfx_pkg::lin_width(MANT_W, MAX_SHIFT);
  localparam int SH_W  = (MAX_SHIFT < 1) ? 1 : $clog2(MAX_SHIFT + 1);

  generate
    if (OUT_W < LIN_W) begin : g_width_check
      $error("output word narrower than the linear range");
    end
  endgenerate

  logic [SH_W-1:0]  shamt;
  logic [OUT_W-1:0] lin_value;

  bfx_exp_clamp #(.EXP_W(EXP_W), .MAX_SHIFT(MAX_SHIFT), .SH_W(SH_W)) u_clamp (
    .exp_in (in_exp),
    .shamt  (shamt)
  );

  bfx_shift #(.MANT_W(MANT_W), .SH_W(SH_W), .OUT_W(OUT_W)) u_shift (
    .mant  (in_mant),
    .shamt (shamt),
    .lin   (lin_value)
  );

  bfx_out_stage #(.W(OUT_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (lin_value),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: rtl/bfx_expander_chk.sv
module bfx_expander_chk #(
  parameter int MANT_W    = 14,
  parameter int EXP_W     = 4,
  parameter int MAX_SHIFT = 7,
  parameter int OUT_W     = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [MANT_W-1:0] in_mant,
  input logic [EXP_W-1:0]  in_exp,
  input logic              out_valid,
  input logic              out_ready,
  input logic [OUT_W-1:0]  out_data
);
  localparam int LIN_W = MANT_W + MAX_SHIFT;
  localparam int TOP_N = OUT_W - LIN_W + 1;

  logic [OUT_W-1:0] ext_mant;
  logic [OUT_W-1:0] model_val;
  int               eff;

  always_comb begin
    ext_mant  = {{(OUT_W-MANT_W){in_mant[MANT_W-1]}}, in_mant};
    eff       = (int'(in_exp) > MAX_SHIFT) ? MAX_SHIFT : int'(in_exp);
    model_val = ext_mant * (OUT_W'(1) << eff);
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid); // R1

  AST_SCALED_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_data == $past(model_val))); // R2

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_data[OUT_W-1:LIN_W-1]) == 0 ||
                   $countones(out_data[OUT_W-1:LIN_W-1]) == TOP_N)); // R4

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
endmodule

bind bfx_expander bfx_expander_chk #(
  .MANT_W(MANT_W), .EXP_W(EXP_W), .MAX_SHIFT(MAX_SHIFT), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mant(in_mant), .in_exp(in_exp), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/bfx_expander_bench.sv
module bfx_expander_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [13:0] in_mant = '0;
  logic [3:0]  in_exp = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bfx_expander u_bfx_expander (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mant(in_mant), .in_exp(in_exp), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  // {mantissa, exponent, expected output}
  localparam int NV = 10;
  localparam logic [41:0] VEC [NV] = '{
    {14'h0001, 4'd0,  24'h000001},  // R2
    {14'h0001, 4'd7,  24'h000080},  // R2 R8
    {14'h1FFF, 4'd7,  24'h0FFF80},  // R2
    {14'h2000, 4'd7,  24'hF00000},  // R4
    {14'h3FFF, 4'd3,  24'hFFFFF8},  // R4
    {14'h0123, 4'd4,  24'h001230},  // R2
    {14'h3FFF, 4'd15, 24'hFFFF80},  // R3
    {14'h0005, 4'd8,  24'h000280},  // R3
    {14'h0000, 4'd7,  24'h000000},  // R2
    {14'h2AAA, 4'd2,  24'hFFAAA8}   // R4
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R1 valid in reset", 32'(out_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", 32'(out_valid), 32'd0);

    // Table walk: back-to-back beats, one per cycle (R5, R8).
    for (int i = 0; i < NV; i++) begin
      in_mant  = VEC[i][41:28];
      in_exp   = VEC[i][27:24];
      in_valid = 1'b1;
      @(negedge clk);
      chk($sformatf("R5 valid vec%0d", i), 32'(out_valid), 32'd1);
      chk($sformatf("R2 data vec%0d", i), 32'(out_data), 32'(VEC[i][23:0]));
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 drained", 32'(out_valid), 32'd0);

    // Stall: beat A held while downstream is not ready (R6, R7).
    out_ready = 1'b0;
    in_mant = 14'h0003; in_exp = 4'd1; in_valid = 1'b1;
    @(negedge clk);
    chk("R6 A data", 32'(out_data), 32'h000006);
    chk("R6 ready low", 32'(in_ready), 32'd0);
    in_mant = 14'h3FFE; in_exp = 4'd2;
    @(negedge clk);
    chk("R6 A held", 32'(out_data), 32'h000006);
    chk("R6 valid held", 32'(out_valid), 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R7 B after release", 32'(out_data), 32'hFFFFF8);
    chk("R7 B valid", 32'(out_valid), 32'd1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 no repeat", 32'(out_valid), 32'd0);

    // Reset during traffic (R1).
    in_mant = 14'h0100; in_exp = 4'd1; in_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 valid cleared", 32'(out_valid), 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule